// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small fully associative address translation cache. Each slot holds one virtual page-pair tag with an address-space tag, a per-slot size mask, a shared-across-spaces flag, and two physical frames. The first frame serves the even page of the pair and the second serves the odd page. A lookup port turns a virtual address and space tag into a physical address, one cycle after the request. A maintenance port handles one operation per cycle: search by key (reporting the slot number), indexed fill, indexed readback, readback at a rotating replacement pointer, and a full clear.

Lookups can bypass translation. In that case the physical address is the virtual address. Every lookup result also carries a no-cache flag, which is derived from two fixed high bits of the virtual address.

Maintenance words use a packed layout:
- Key word: the pair tag shifted left by 11, ORed with the space tag.
- Half word: `{frame, cache code[2:0], dirty, valid, shared}`.
- Mask word: the mask shifted left by 11.

Top module: `tlb_paired_top`

## Requirements
- R1: Reset and the clear operation (mt_op_i = 5) empty every slot and set the replacement pointer to 0. After either one, lookups and key searches miss and readback of any slot returns all-zero words.
- R2: A slot matches when it is occupied (either half word has its valid bit, bit 1, set). The incoming pair tag (va[31:13] for lookups) must also equal the stored tag in every bit whose mask bit is clear. Finally, the shared flag must be set or the space tags must be equal.
- R3: When several slots match, the lowest-numbered slot supplies the result.
- R4: For a mask with its k low bits set, va[12+k] selects the odd half (1) or the even half (0). The physical address is the chosen frame shifted left by 12 with its low 12+k bits replaced by the matching virtual bits. Dirty and cache code come from the chosen half.
- R5: A match whose chosen half has valid clear reports hit=1 with lk_inval_o=1. It is not reported as a miss.
- R6: A key search (mt_op_i = 1) reports the matching slot number on pr_idx_o, or all ones on a miss.
- R7: An indexed fill (mt_op_i = 2) replaces every field of the addressed slot. The shared flag is the AND of bit 0 of both half words. A fill whose index is ENTRIES or larger changes nothing.
- R8: An indexed readback (mt_op_i = 3) returns the slot in the packed layout. An index of ENTRIES or larger returns zeros.
- R9: A pointer readback (mt_op_i = 4) returns the slot at the replacement pointer together with its number. When mt_adv_i is set, the pointer advances in the same operation, wrapping from ENTRIES-1 to 0.
- R10: With lk_phys_i set, a lookup reports a hit, lk_pa_o equal to the virtual address, and zero dirty, invalid and cache code.
- R11: lk_unc_o is set exactly when virtual address bits 31 and 29 are both 1, in every mode.
- R12: Lookup and maintenance results appear on the clock edge after the request. A lookup sees the table as it stood before a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req_i | input | 1 | Lookup request |
| lk_phys_i | input | 1 | Bypass translation for this lookup |
| lk_va_i | input | VA_W | Virtual address |
| lk_asid_i | input | ASID_W | Address-space tag |
| mt_op_i | input | 3 | 0 idle, 1 search, 2 fill, 3 indexed read, 4 pointer read, 5 clear |
| mt_idx_i | input | IDXP_W | Slot index for fill and indexed read |
| mt_adv_i | input | 1 | Advance pointer on pointer read |
| mt_hi_i | input | HI_W | Key word (fill data and search key) |
| mt_lo0_i | input | LO_W | Even half word |
| mt_lo1_i | input | LO_W | Odd half word |
| mt_mask_i | input | MK_W | Mask word |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_inval_o | output | 1 | Hit on a half with valid clear |
| lk_pa_o | output | PA_W | Physical address |
| lk_dirty_o | output | 1 | Dirty bit of chosen half |
| lk_cca_o | output | 3 | Cache code of chosen half |
| lk_unc_o | output | 1 | No-cache region flag |
| mt_vld_o | output | 1 | Search or readback result valid |
| pr_idx_o | output | IDXP_W | Search result slot or all ones |
| rd_idx_o | output | IDXP_W | Slot number of readback |
| rd_hi_o | output | HI_W | Readback key word |
| rd_lo0_o | output | LO_W | Readback even half |
| rd_lo1_o | output | LO_W | Readback odd half |
| rd_mask_o | output | MK_W | Readback mask word |

## Verification
The bench builds the block with ENTRIES = 6 and defaults elsewhere (32-bit addresses, 8-bit space tags, 16-bit mask, 20-bit frames). The slot count is not a power of two, so the 4-bit index reaches values 6 to 15, which must be dropped on fill and read as zero. For the same reason, the pointer wrap from 5 back to 0 is an explicit comparison rather than a natural overflow. The 16-bit mask allows a slot with a two-bit mask, which moves the odd/even select to va[14] and widens the offset merge. The vector table covers duplicate tags, shared slots, invalid halves and both no-cache region bits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_PROBE    = 3'd1,
    OP_WRITE    = 3'd2,
    OP_READ_IDX = 3'd3,
    OP_READ_NXT = 3'd4,
    OP_FLUSH    = 3'd5
  } tlb_op_e;

  // Offset bits of the smallest page; the pair tag starts one bit above.
  localparam int BASE_SHIFT = 12;
  // Left shift of tag and mask inside maintenance words.
  localparam int PACK_SHIFT = 11;
  // Both bits of this pattern set means a no-cache region.
  localparam logic [31:0] UNC_REGION = 32'hA000_0000;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic [VPN_W-1:0]   key_vpn_i,
  input  logic [ASID_W-1:0]  key_asid_i,
  input  logic [VPN_W-1:0]   vpn_i  [ENTRIES],
  input  logic [ASID_W-1:0]  asid_i [ENTRIES],
  input  logic [MASK_W-1:0]  mask_i [ENTRIES],
  input  logic [ENTRIES-1:0] g_i,
  input  logic [ENTRIES-1:0] occ_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [ENTRIES-1:0] m;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] care;
    assign care = ~VPN_W'(mask_i[i]);
    assign m[i] = occ_i[i]
                && (((key_vpn_i ^ vpn_i[i]) & care) == '0)
                && (g_i[i] || (key_asid_i == asid_i[i]));
  end

  // Lowest slot number wins: scan from the top so the last write is lowest.
  always_comb begin
    hit_o = |m;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int MASK_W  = 16,
  parameter int IDX_W   = 3,
  parameter int IDXP_W  = 4,
  parameter int HI_W    = 30,
  parameter int LO_W    = 26,
  parameter int MK_W    = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  tlb_op_e            op_i,
  input  logic [IDXP_W-1:0]  idx_i,
  input  logic               adv_i,
  input  logic [HI_W-1:0]    hi_i,
  input  logic [LO_W-1:0]    lo0_i,
  input  logic [LO_W-1:0]    lo1_i,
  input  logic [MK_W-1:0]    mask_i,
  output logic [VPN_W-1:0]   vpn_o  [ENTRIES],
  output logic [ASID_W-1:0]  asid_o [ENTRIES],
  output logic [MASK_W-1:0]  mask_o [ENTRIES],
  output logic [ENTRIES-1:0] g_o,
  output logic [ENTRIES-1:0] occ_o,
  output logic [PFN_W-1:0]   pfn_o  [ENTRIES][2],
  output logic [2:0]         cca_o  [ENTRIES][2],
  output logic [1:0]         d_o    [ENTRIES],
  output logic [1:0]         v_o    [ENTRIES],
  output logic [IDXP_W-1:0]  rd_idx_o,
  output logic [HI_W-1:0]    rd_hi_o,
  output logic [LO_W-1:0]    rd_lo0_o,
  output logic [LO_W-1:0]    rd_lo1_o,
  output logic [MK_W-1:0]    rd_mask_o
);

  logic [IDX_W-1:0] nxt_q;
  logic             in_range;
  logic             unused_bits;

  assign in_range    = idx_i < IDXP_W'(ENTRIES);
  assign unused_bits = ^{hi_i[PACK_SHIFT-1:ASID_W], mask_i[PACK_SHIFT-1:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_occ
    assign occ_o[i] = v_o[i][0] | v_o[i][1];
  end

  function automatic logic [LO_W-1:0] pack_lo(input logic [PFN_W-1:0] pfn,
      input logic [2:0] cca, input logic d, input logic v, input logic g);
    return {pfn, cca, d, v, g};
  endfunction

  always_ff @(posedge clk) begin
    if (rst || op_i == OP_FLUSH) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_o[i]  <= '0;
        asid_o[i] <= '0;
        mask_o[i] <= '0;
        g_o[i]    <= 1'b0;
        d_o[i]    <= '0;
        v_o[i]    <= '0;
        for (int h = 0; h < 2; h++) begin
          pfn_o[i][h] <= '0;
          cca_o[i][h] <= '0;
        end
      end
      nxt_q <= '0;
    end else begin
      if (op_i == OP_WRITE && in_range) begin
        vpn_o[idx_i[IDX_W-1:0]]    <= hi_i[HI_W-1:PACK_SHIFT];
        asid_o[idx_i[IDX_W-1:0]]   <= hi_i[ASID_W-1:0];
        mask_o[idx_i[IDX_W-1:0]]   <= mask_i[MK_W-1:PACK_SHIFT];
        g_o[idx_i[IDX_W-1:0]]      <= lo0_i[0] & lo1_i[0];
        v_o[idx_i[IDX_W-1:0]]      <= {lo1_i[1], lo0_i[1]};
        d_o[idx_i[IDX_W-1:0]]      <= {lo1_i[2], lo0_i[2]};
        cca_o[idx_i[IDX_W-1:0]][0] <= lo0_i[5:3];
        cca_o[idx_i[IDX_W-1:0]][1] <= lo1_i[5:3];
        pfn_o[idx_i[IDX_W-1:0]][0] <= lo0_i[LO_W-1:6];
        pfn_o[idx_i[IDX_W-1:0]][1] <= lo1_i[LO_W-1:6];
      end
      if (op_i == OP_READ_NXT && adv_i)
        nxt_q <= (nxt_q == IDX_W'(ENTRIES - 1)) ? '0 : nxt_q + 1'b1;
    end
  end

  // Readback register; the slot sampled is the pre-edge content.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx_o  <= '0;
      rd_hi_o   <= '0;
      rd_lo0_o  <= '0;
      rd_lo1_o  <= '0;
      rd_mask_o <= '0;
    end else if (op_i == OP_READ_IDX || op_i == OP_READ_NXT) begin
      logic [IDX_W-1:0] s;
      logic             ok;
      s  = (op_i == OP_READ_NXT) ? nxt_q : idx_i[IDX_W-1:0];
      ok = (op_i == OP_READ_NXT) || in_range;
      rd_idx_o <= (op_i == OP_READ_NXT) ? IDXP_W'(nxt_q) : idx_i;
      if (ok) begin
        rd_hi_o   <= {vpn_o[s], {PACK_SHIFT{1'b0}}} | HI_W'(asid_o[s]);
        rd_lo0_o  <= pack_lo(pfn_o[s][0], cca_o[s][0], d_o[s][0], v_o[s][0], g_o[s]);
        rd_lo1_o  <= pack_lo(pfn_o[s][1], cca_o[s][1], d_o[s][1], v_o[s][1], g_o[s]);
        rd_mask_o <= {mask_o[s], {PACK_SHIFT{1'b0}}};
      end else begin
        rd_hi_o   <= '0;
        rd_lo0_o  <= '0;
        rd_lo1_o  <= '0;
        rd_mask_o <= '0;
      end
    end
  end

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (rst)
    nxt_q < IDX_W'(ENTRIES));

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_READ_NXT && adv_i && nxt_q == IDX_W'(ENTRIES - 1)) |=> nxt_q == '0);

  assert_flush_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_FLUSH) |=> (occ_o == '0 && nxt_q == '0));

  assert_oob_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_WRITE && !in_range) |=> $stable(occ_o) && $stable(g_o));

endmodule

// File: rtl/tlb_paired_top.sv
module tlb_paired_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int MASK_W  = 16,
  localparam int VPN_W  = VA_W - BASE_SHIFT - 1,
  localparam int PA_W   = PFN_W + BASE_SHIFT,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int IDXP_W = IDX_W + 1,
  localparam int HI_W   = VPN_W + PACK_SHIFT,
  localparam int LO_W   = PFN_W + 6,
  localparam int MK_W   = MASK_W + PACK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req_i,
  input  logic              lk_phys_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [2:0]        mt_op_i,
  input  logic [IDXP_W-1:0] mt_idx_i,
  input  logic              mt_adv_i,
  input  logic [HI_W-1:0]   mt_hi_i,
  input  logic [LO_W-1:0]   mt_lo0_i,
  input  logic [LO_W-1:0]   mt_lo1_i,
  input  logic [MK_W-1:0]   mt_mask_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  output logic              lk_inval_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic              lk_dirty_o,
  output logic [2:0]        lk_cca_o,
  output logic              lk_unc_o,
  output logic              mt_vld_o,
  output logic [IDXP_W-1:0] pr_idx_o,
  output logic [IDXP_W-1:0] rd_idx_o,
  output logic [HI_W-1:0]   rd_hi_o,
  output logic [LO_W-1:0]   rd_lo0_o,
  output logic [LO_W-1:0]   rd_lo1_o,
  output logic [MK_W-1:0]   rd_mask_o
);

  tlb_op_e op;
  assign op = tlb_op_e'(mt_op_i);

  logic [VPN_W-1:0]   vpn_a  [ENTRIES];
  logic [ASID_W-1:0]  asid_a [ENTRIES];
  logic [MASK_W-1:0]  mask_a [ENTRIES];
  logic [ENTRIES-1:0] g_a, occ_a;
  logic [PFN_W-1:0]   pfn_a  [ENTRIES][2];
  logic [2:0]         cca_a  [ENTRIES][2];
  logic [1:0]         d_a    [ENTRIES];
  logic [1:0]         v_a    [ENTRIES];

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W),
    .MASK_W(MASK_W), .IDX_W(IDX_W), .IDXP_W(IDXP_W), .HI_W(HI_W),
    .LO_W(LO_W), .MK_W(MK_W)
  ) u_store (
    .clk(clk), .rst(rst), .op_i(op), .idx_i(mt_idx_i), .adv_i(mt_adv_i),
    .hi_i(mt_hi_i), .lo0_i(mt_lo0_i), .lo1_i(mt_lo1_i), .mask_i(mt_mask_i),
    .vpn_o(vpn_a), .asid_o(asid_a), .mask_o(mask_a), .g_o(g_a), .occ_o(occ_a),
    .pfn_o(pfn_a), .cca_o(cca_a), .d_o(d_a), .v_o(v_a),
    .rd_idx_o(rd_idx_o), .rd_hi_o(rd_hi_o), .rd_lo0_o(rd_lo0_o),
    .rd_lo1_o(rd_lo1_o), .rd_mask_o(rd_mask_o)
  );

  logic             lk_hit, pr_hit;
  logic [IDX_W-1:0] lk_idx, pr_idx;

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .IDX_W(IDX_W)
  ) u_lk_match (
    .key_vpn_i(lk_va_i[VA_W-1:BASE_SHIFT+1]), .key_asid_i(lk_asid_i),
    .vpn_i(vpn_a), .asid_i(asid_a), .mask_i(mask_a), .g_i(g_a), .occ_i(occ_a),
    .hit_o(lk_hit), .idx_o(lk_idx)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .IDX_W(IDX_W)
  ) u_pr_match (
    .key_vpn_i(mt_hi_i[HI_W-1:PACK_SHIFT]), .key_asid_i(mt_hi_i[ASID_W-1:0]),
    .vpn_i(vpn_a), .asid_i(asid_a), .mask_i(mask_a), .g_i(g_a), .occ_i(occ_a),
    .hit_o(pr_hit), .idx_o(pr_idx)
  );

  // Half select and offset merge for the winning slot.
  logic              half;
  logic [PA_W-1:0]   offm;
  logic [PA_W-1:0]   pa_map;
  logic [MASK_W-1:0] msk;
  logic              unc;

  always_comb begin
    msk  = mask_a[lk_idx];
    half = lk_va_i[BASE_SHIFT];
    offm = '0;
    offm[BASE_SHIFT-1:0] = '1;
    for (int i = 0; i < MASK_W; i++) begin
      if (msk[i]) begin
        half = lk_va_i[BASE_SHIFT + 1 + i];
        offm[BASE_SHIFT + i] = 1'b1;
      end
    end
    pa_map = ({pfn_a[lk_idx][half], {BASE_SHIFT{1'b0}}} & ~offm)
           | (PA_W'(lk_va_i) & offm);
    unc    = (lk_va_i[31:0] & UNC_REGION) == UNC_REGION;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld_o   <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_inval_o <= 1'b0;
      lk_pa_o    <= '0;
      lk_dirty_o <= 1'b0;
      lk_cca_o   <= '0;
      lk_unc_o   <= 1'b0;
    end else begin
      lk_vld_o <= lk_req_i;
      if (lk_req_i) begin
        lk_unc_o <= unc;
        if (lk_phys_i) begin
          lk_hit_o   <= 1'b1;
          lk_inval_o <= 1'b0;
          lk_pa_o    <= PA_W'(lk_va_i);
          lk_dirty_o <= 1'b0;
          lk_cca_o   <= '0;
        end else if (lk_hit) begin
          lk_hit_o   <= 1'b1;
          lk_inval_o <= ~v_a[lk_idx][half];
          lk_pa_o    <= pa_map;
          lk_dirty_o <= d_a[lk_idx][half];
          lk_cca_o   <= cca_a[lk_idx][half];
        end else begin
          lk_hit_o   <= 1'b0;
          lk_inval_o <= 1'b0;
          lk_pa_o    <= '0;
          lk_dirty_o <= 1'b0;
          lk_cca_o   <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mt_vld_o <= 1'b0;
      pr_idx_o <= '1;
    end else begin
      mt_vld_o <= (op == OP_PROBE) || (op == OP_READ_IDX) || (op == OP_READ_NXT);
      if (op == OP_PROBE)
        pr_idx_o <= pr_hit ? IDXP_W'(pr_idx) : '1;
    end
  end

  assert_lk_latency_R12: assert property (@(posedge clk) disable iff (rst)
    lk_req_i |=> lk_vld_o);

  assert_lk_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !lk_req_i |=> !lk_vld_o);

  assert_phys_ident_R10: assert property (@(posedge clk) disable iff (rst)
    (lk_req_i && lk_phys_i) |=> (lk_hit_o && lk_pa_o == PA_W'($past(lk_va_i))));

  assert_inval_is_hit_R5: assert property (@(posedge clk) disable iff (rst)
    lk_inval_o |-> lk_hit_o);

  assert_unc_region_R11: assert property (@(posedge clk) disable iff (rst)
    lk_req_i |=> lk_unc_o == ($past(lk_va_i[31]) && $past(lk_va_i[29])));

  assert_probe_code_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PROBE) |=> (pr_idx_o == '1 || pr_idx_o < IDXP_W'(ENTRIES)));

endmodule

// File: tb/tlb_paired_top_tb.sv
module tlb_paired_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT = 6;
  localparam int WDOG = 20000;
  localparam int N_VEC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0, lk_phys = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic [2:0]  mt_op = '0;
  logic [3:0]  mt_idx = '0;
  logic        mt_adv = 1'b0;
  logic [29:0] mt_hi = '0;
  logic [25:0] mt_lo0 = '0, mt_lo1 = '0;
  logic [26:0] mt_mask = '0;

  logic        lk_vld, lk_hit, lk_inval, lk_dirty, lk_unc, mt_vld;
  logic [31:0] lk_pa;
  logic [2:0]  lk_cca;
  logic [3:0]  pr_idx, rd_idx;
  logic [29:0] rd_hi;
  logic [25:0] rd_lo0, rd_lo1;
  logic [26:0] rd_mask;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_paired_top #(.ENTRIES(N_ENT)) u_dut (
    .clk(clk), .rst(rst), .lk_req_i(lk_req), .lk_phys_i(lk_phys),
    .lk_va_i(lk_va), .lk_asid_i(lk_asid), .mt_op_i(mt_op), .mt_idx_i(mt_idx),
    .mt_adv_i(mt_adv), .mt_hi_i(mt_hi), .mt_lo0_i(mt_lo0), .mt_lo1_i(mt_lo1),
    .mt_mask_i(mt_mask), .lk_vld_o(lk_vld), .lk_hit_o(lk_hit),
    .lk_inval_o(lk_inval), .lk_pa_o(lk_pa), .lk_dirty_o(lk_dirty),
    .lk_cca_o(lk_cca), .lk_unc_o(lk_unc), .mt_vld_o(mt_vld),
    .pr_idx_o(pr_idx), .rd_idx_o(rd_idx), .rd_hi_o(rd_hi), .rd_lo0_o(rd_lo0),
    .rd_lo1_o(rd_lo1), .rd_mask_o(rd_mask)
  );

  // {va, asid, phys, hit, inval, pa, dirty, cca, unc}
  localparam logic [79:0] VECS [N_VEC] = '{
    {32'h00020123, 8'h05, 1'b0, 1'b1, 1'b0, 32'h11111123, 1'b1, 3'd3, 1'b0},
    {32'h00021456, 8'h05, 1'b0, 1'b1, 1'b0, 32'h22222456, 1'b0, 3'd2, 1'b0},
    {32'h00020123, 8'h06, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 3'd0, 1'b0},
    {32'h00040abc, 8'h33, 1'b0, 1'b1, 1'b0, 32'h33333abc, 1'b0, 3'd0, 1'b0},
    {32'h00041abc, 8'h33, 1'b0, 1'b1, 1'b1, 32'h44444abc, 1'b0, 3'd0, 1'b0},
    {32'h00203210, 8'h09, 1'b0, 1'b1, 1'b0, 32'h55553210, 1'b1, 3'd5, 1'b0},
    {32'h00206fff, 8'h09, 1'b0, 1'b1, 1'b0, 32'h66662fff, 1'b0, 3'd1, 1'b0},
    {32'h00208000, 8'h09, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 3'd0, 1'b0},
    {32'hA0000010, 8'h01, 1'b0, 1'b1, 1'b0, 32'h0A000010, 1'b0, 3'd2, 1'b1},
    {32'hA0000010, 8'h01, 1'b1, 1'b1, 1'b0, 32'hA0000010, 1'b0, 3'd0, 1'b1},
    {32'h00020123, 8'h05, 1'b1, 1'b1, 1'b0, 32'h00020123, 1'b0, 3'd0, 1'b0},
    {32'hB0000000, 8'h02, 1'b1, 1'b1, 1'b0, 32'hB0000000, 1'b0, 3'd0, 1'b1},
    {32'h80000000, 8'h02, 1'b1, 1'b1, 1'b0, 32'h80000000, 1'b0, 3'd0, 1'b0},
    {32'hE0000000, 8'h03, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 3'd0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R3";
      1, 5, 6: return "R4";
      2, 3, 7: return "R2";
      4: return "R5";
      9, 10: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [25:0] half_w(input logic [19:0] pfn, input logic [2:0] cca,
                                         input logic d, input logic v, input logic g);
    return {pfn, cca, d, v, g};
  endfunction

  function automatic logic [29:0] key_w(input logic [18:0] vpn, input logic [7:0] asid);
    return {vpn, 11'b0} | 30'(asid);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [18:0] vpn, input logic [7:0] asid,
                    input logic [15:0] msk, input logic [25:0] l0, input logic [25:0] l1);
    mt_op = 3'd2; mt_idx = idx; mt_hi = key_w(vpn, asid);
    mt_lo0 = l0; mt_lo1 = l1; mt_mask = {msk, 11'b0};
    @(negedge clk);
    mt_op = 3'd0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic phys);
    lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_phys = phys;
    @(negedge clk);
    lk_req = 1'b0; lk_phys = 1'b0;
  endtask

  task automatic probe(input logic [18:0] vpn, input logic [7:0] asid);
    mt_op = 3'd1; mt_hi = key_w(vpn, asid);
    @(negedge clk);
    mt_op = 3'd0;
  endtask

  task automatic rd_at(input logic [3:0] idx);
    mt_op = 3'd3; mt_idx = idx;
    @(negedge clk);
    mt_op = 3'd0;
  endtask

  task automatic rd_nxt(input logic adv);
    mt_op = 3'd4; mt_adv = adv;
    @(negedge clk);
    mt_op = 3'd0; mt_adv = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 valids after reset", {62'b0, lk_vld, mt_vld}, 64'd0);
    rd_at(4'd0);
    chk("R1 read slot0 after reset", {rd_hi, rd_lo0}, 64'd0);
    rd_nxt(1'b0);
    chk("R1 pointer after reset", 64'(rd_idx), 64'd0);
    probe(19'h0, 8'h0);
    chk("R1 search misses after reset", 64'(pr_idx), 64'hF);
    lookup(32'h0, 8'h0, 1'b0);
    chk("R1 lookup misses after reset", {63'b0, lk_hit}, 64'd0);

    // fill slots
    wr(4'd0, 19'h00010, 8'h05, 16'h0,
       half_w(20'h11111, 3'd3, 1, 1, 0), half_w(20'h22222, 3'd2, 0, 1, 0));
    wr(4'd1, 19'h00020, 8'h07, 16'h0,
       half_w(20'h33333, 3'd0, 0, 1, 1), half_w(20'h44444, 3'd0, 0, 0, 1));
    wr(4'd2, 19'h00100, 8'h09, 16'h3,
       half_w(20'h55550, 3'd5, 1, 1, 0), half_w(20'h66660, 3'd1, 0, 1, 0));
    wr(4'd3, 19'h00010, 8'h05, 16'h0,
       half_w(20'h77777, 3'd4, 1, 1, 0), half_w(20'h78888, 3'd4, 0, 1, 0));
    wr(4'd4, 19'h50000, 8'h01, 16'h0,
       half_w(20'h0A000, 3'd2, 0, 1, 0), half_w(20'h0A001, 3'd2, 1, 1, 0));
    wr(4'd6, 19'h00030, 8'h05, 16'h0,
       half_w(20'h0BBBB, 3'd0, 0, 1, 1), half_w(20'h0CCCC, 3'd0, 0, 1, 1));
    wr(4'd15, 19'h00030, 8'h05, 16'h0,
       half_w(20'h0BBBB, 3'd0, 0, 1, 1), half_w(20'h0CCCC, 3'd0, 0, 1, 1));

    // vector table
    for (int i = 0; i < N_VEC; i++) begin
      logic [79:0] v;
      v = VECS[i];
      lookup(v[79:48], v[47:40], v[39]);
      chk(vec_tag(i), {25'b0, lk_vld, lk_hit, lk_inval, lk_pa, lk_dirty, lk_cca, lk_unc},
          {25'b0, 1'b1, v[38:0]});
    end

    // R6: search
    probe(19'h00102, 8'h09);
    chk("R6 search masked slot", 64'(pr_idx), 64'd2);
    probe(19'h00010, 8'h05);
    chk("R6 search duplicate gives lowest (R3)", 64'(pr_idx), 64'd0);
    probe(19'h00020, 8'h44);
    chk("R6 search shared slot", 64'(pr_idx), 64'd1);
    probe(19'h00010, 8'h06);
    chk("R6 search miss code", {63'b0, mt_vld} << 4 | 64'(pr_idx), 64'h1F);

    // R8: packed readback
    rd_at(4'd2);
    chk("R8 key word slot2", 64'(rd_hi), 64'(key_w(19'h00100, 8'h09)));
    chk("R8 half words slot2", {12'b0, rd_lo0, rd_lo1},
        {12'b0, half_w(20'h55550, 3'd5, 1, 1, 0), half_w(20'h66660, 3'd1, 0, 1, 0)});
    chk("R8 mask word slot2", 64'(rd_mask), 64'(27'h3 << 11));
    rd_at(4'd1);
    chk("R8 shared flag on both halves (R7)", {12'b0, rd_lo0, rd_lo1},
        {12'b0, half_w(20'h33333, 3'd0, 0, 1, 1), half_w(20'h44444, 3'd0, 0, 0, 1)});
    rd_at(4'd6);
    chk("R8 out-of-range read zero", {rd_hi, rd_lo0}, 64'd0);
    rd_at(4'd5);
    chk("R7 slot5 untouched by dropped fills", {rd_hi, rd_lo0}, 64'd0);

    // R7: dropped fill not visible
    lookup(32'h00060000, 8'h05, 1'b0);
    chk("R7 dropped fill lookup miss", {63'b0, lk_hit}, 64'd0);
    probe(19'h00030, 8'h05);
    chk("R7 dropped fill search miss", 64'(pr_idx), 64'hF);

    // R12: fill and lookup in the same cycle
    mt_op = 3'd2; mt_idx = 4'd5; mt_hi = key_w(19'h00040, 8'h05);
    mt_lo0 = half_w(20'h12345, 3'd6, 1, 1, 0); mt_lo1 = half_w(20'h0, 3'd0, 0, 0, 0);
    mt_mask = '0;
    lk_req = 1'b1; lk_va = 32'h00080000; lk_asid = 8'h05;
    @(negedge clk);
    mt_op = 3'd0; lk_req = 1'b0;
    chk("R12 same-cycle fill not seen", {62'b0, lk_vld, lk_hit}, 64'd2);
    lookup(32'h00080000, 8'h05, 1'b0);
    chk("R12 fill seen next cycle", {31'b0, lk_hit, lk_pa}, {31'b0, 1'b1, 32'h12345000});

    // R7 replace: slot0 emptied, duplicate at slot3 takes over
    wr(4'd0, 19'h00010, 8'h05, 16'h0, 26'h0, 26'h0);
    lookup(32'h00020123, 8'h05, 1'b0);
    chk("R7 replaced slot0, slot3 answers", {31'b0, lk_hit, lk_pa}, {31'b0, 1'b1, 32'h77777123});

    // R9: pointer readback
    rd_nxt(1'b0);
    chk("R9 no advance", 64'(rd_idx), 64'd0);
    rd_nxt(1'b0);
    chk("R9 still slot0", 64'(rd_idx), 64'd0);
    for (int k = 0; k < N_ENT; k++) begin
      rd_nxt(1'b1);
      chk("R9 advancing index", 64'(rd_idx), 64'(k));
      if (k == 2) chk("R9 data at pointer", 64'(rd_hi), 64'(key_w(19'h00100, 8'h09)));
    end
    rd_nxt(1'b0);
    chk("R9 wrap to 0", 64'(rd_idx), 64'd0);

    // R1: clear
    rd_nxt(1'b1);
    rd_nxt(1'b1);
    mt_op = 3'd5;
    @(negedge clk);
    mt_op = 3'd0;
    rd_nxt(1'b0);
    chk("R1 pointer after clear", 64'(rd_idx), 64'd0);
    lookup(32'h00020123, 8'h05, 1'b0);
    chk("R1 lookup after clear", {63'b0, lk_hit}, 64'd0);
    rd_at(4'd2);
    chk("R1 read after clear", {rd_hi, rd_lo1}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule